// File: doc/BRIEF.md
# PHY Test Interface Master

This block drives the serial test/control port of one of several D-PHY instances, one pin at a time. The port has a test clock, a test enable, an 8-bit input bus and an 8-bit output bus, plus a test-clear line. A single command port accepts four operations: a register write (code and data), a register read (code only), and setting or releasing test-clear. Every pin change is followed by a fixed hold of `HOLD_CYC` clock cycles before the next pin may move. The default is sized for roughly one microsecond at a typical control clock.

A write runs the code phase, then the data phase, and then returns the byte the PHY presents on its output bus as a monitor value. A read runs the code phase, captures the output bus, and then runs a data phase that writes the captured byte back, so the register keeps its value. The captured byte is returned. A PHY-select field on each command routes all pin activity to one instance. Every other instance keeps its pins exactly as they were.

Top module: `phy_test_if_master`

## Requirements
- R1: During and after a synchronous active-low reset, every test clock, test enable, input-bus and test-clear output is 0, `cmd_ready` is 1 and `rsp_valid` is 0.
- R2: A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both 1. `cmd_ready` stays 0 until that command has finished.
- R3: The code phase, in order: test clock to 1, input bus to the code, test enable to 1, test clock to 0, test enable to 0. Test enable only rises while test clock is 1.
- R4: The data phase, in order: test clock to 0 (a slot is spent even if it is already 0), input bus to the data byte, test clock to 1.
- R5: `cmd_op` = 0 is a write. Its response is the selected PHY's output bus sampled one hold after the final test-clock rise. `rsp_valid` pulses for exactly one cycle.
- R6: `cmd_op` = 1 is a read. The output bus is captured one hold after the code phase's last change. The data phase drives that captured byte, and the response carries it.
- R7: Pin changes of a read or write fall on the accepting edge plus k·`HOLD_CYC` cycles, k = 0..7. The response and the return of `cmd_ready` follow at 8·`HOLD_CYC` cycles. No two pin changes are closer than `HOLD_CYC` cycles.
- R8: Only the instance selected by `cmd_phy` (instance i uses bit slice i of each pin vector and byte slice i of the buses) changes its pins. All other instances hold their pins.
- R9: `cmd_op` = 2 sets and `cmd_op` = 3 releases test-clear of the selected instance on the accepting edge. No other pin moves and no response is produced. `cmd_ready` returns `HOLD_CYC` cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Block idle, command may be taken |
| cmd_op | input | 2 | 0 write, 1 read, 2 set test-clear, 3 release test-clear |
| cmd_phy | input | SEL_W | Target PHY instance |
| cmd_code | input | DATA_W | Test code (register address) |
| cmd_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_data | output | DATA_W | Monitor byte (write) or read byte |
| tclk_o | output | NUM_PHY | Test clock per instance |
| ten_o | output | NUM_PHY | Test enable per instance |
| tdin_o | output | NUM_PHY*DATA_W | Test input bus per instance |
| tclr_o | output | NUM_PHY | Test-clear per instance |
| tdout_i | input | NUM_PHY*DATA_W | Test output bus per instance |

## Verification
The accepting edge is the reference point for all timing. Pin step k is visible just after edge k·`HOLD_CYC` from that edge. The read capture happens at step 5. The response and `cmd_ready` follow at 8·`HOLD_CYC` cycles. A test-clear command completes at `HOLD_CYC`. The driver samples pins on the falling edge right after each step edge, and again one cycle before it, to confirm that nothing moved early. The expected response and its due cycle are queued when the command is issued. The monitor compares both the data and the cycle number when `rsp_valid` appears, and flags any response it did not expect.

// File: rtl/tif_pkg.sv
// Shared types for the PHY test interface master.
// Assumes 8 pin steps per transfer; step numbering is behaviour, not layout.
package tif_pkg;

    typedef enum logic [1:0] {
        TIF_OP_WRITE   = 2'd0,
        TIF_OP_READ    = 2'd1,
        TIF_OP_CLR_SET = 2'd2,
        TIF_OP_CLR_REL = 2'd3
    } tif_op_e;

    typedef enum logic [2:0] {
        ACT_CLK_HI,
        ACT_CLK_LO,
        ACT_EN_HI,
        ACT_EN_LO,
        ACT_DIN,
        ACT_CLR_HI,
        ACT_CLR_LO,
        ACT_NOP
    } tif_act_e;

    localparam int STEP_W = 3;
    localparam logic [STEP_W-1:0] XFER_LAST_STEP = 3'd7;
    localparam logic [STEP_W-1:0] CODE_DIN_STEP  = 3'd1;
    localparam logic [STEP_W-1:0] DATA_DIN_STEP  = 3'd6;
    // A read captures the output bus on the edge that starts this step.
    localparam logic [STEP_W-1:0] CAPTURE_STEP   = 3'd5;

    // Pin action performed at a given step of a given operation.
    function automatic tif_act_e tif_step_act(tif_op_e op, logic [STEP_W-1:0] step);
        tif_act_e a;
        a = ACT_NOP;
        if (op == TIF_OP_CLR_SET) begin
            a = ACT_CLR_HI;
        end else if (op == TIF_OP_CLR_REL) begin
            a = ACT_CLR_LO;
        end else begin
            case (step)
                3'd0: a = ACT_CLK_HI;
                3'd1: a = ACT_DIN;
                3'd2: a = ACT_EN_HI;
                3'd3: a = ACT_CLK_LO;
                3'd4: a = ACT_EN_LO;
                3'd5: a = ACT_CLK_LO;
                3'd6: a = ACT_DIN;
                default: a = ACT_CLK_HI;
            endcase
        end
        return a;
    endfunction

endpackage

// File: rtl/tif_hold_timer.sv
// Hold timer: after a load it reports expiry HOLD_CYC cycles later.
// Assumes HOLD_CYC >= 1; load has priority over counting.
module tif_hold_timer #(
    parameter int HOLD_CYC = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic expired
);
    localparam int CNT_W = (HOLD_CYC > 1) ? $clog2(HOLD_CYC + 1) : 1;

    logic [CNT_W-1:0] cnt_q;

    // Count down from HOLD_CYC-1 to zero after each load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= CNT_W'(HOLD_CYC - 1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/tif_sequencer.sv
// Command sequencer: takes one command at a time and steps through its pin
// actions, one per hold interval, capturing and returning the result byte.
// Assumes hold_done is the expiry of a timer loaded on every act_fire.
module tif_sequencer
    import tif_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int SEL_W  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  tif_op_e           cmd_op,
    input  logic [SEL_W-1:0]  cmd_phy,
    input  logic [DATA_W-1:0] cmd_code,
    input  logic [DATA_W-1:0] cmd_wdata,
    input  logic              hold_done,
    input  logic [DATA_W-1:0] tdout_sel,
    output logic [SEL_W-1:0]  cur_phy,
    output logic              act_fire,
    output tif_act_e          act_kind,
    output logic [SEL_W-1:0]  act_phy,
    output logic [DATA_W-1:0] act_byte,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data
);
    typedef enum logic { SQ_IDLE, SQ_RUN } sq_state_e;

    sq_state_e         state_q;
    tif_op_e           op_q;
    logic [SEL_W-1:0]  phy_q;
    logic [DATA_W-1:0] code_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] cap_q;
    logic [STEP_W-1:0] step_q;

    logic              accept;
    logic              at_last;
    logic              advance;
    logic              finish;
    logic              is_xfer_q;
    logic [STEP_W-1:0] nxt_step;
    tif_op_e           nxt_op;

    // Decode handshake and step progress.
    always_comb begin
        is_xfer_q = (op_q == TIF_OP_WRITE) || (op_q == TIF_OP_READ);
        at_last   = is_xfer_q ? (step_q == XFER_LAST_STEP) : (step_q == '0);
        accept    = (state_q == SQ_IDLE) && cmd_valid;
        advance   = (state_q == SQ_RUN) && hold_done && !at_last;
        finish    = (state_q == SQ_RUN) && hold_done && at_last;
        nxt_step  = accept ? '0 : (step_q + 1'b1);
        nxt_op    = accept ? cmd_op : op_q;
    end

    // Select the pin action and its byte for the step now starting.
    always_comb begin
        act_fire = accept || advance;
        act_kind = tif_step_act(nxt_op, nxt_step);
        act_phy  = accept ? cmd_phy : phy_q;
        if (nxt_step == CODE_DIN_STEP) begin
            act_byte = code_q;
        end else if (op_q == TIF_OP_READ) begin
            act_byte = cap_q;
        end else begin
            act_byte = wdata_q;
        end
    end

    // Command state, step counter, read capture and response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= SQ_IDLE;
            op_q      <= TIF_OP_WRITE;
            phy_q     <= '0;
            code_q    <= '0;
            wdata_q   <= '0;
            cap_q     <= '0;
            step_q    <= '0;
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= 1'b0;
            if (accept) begin
                state_q <= SQ_RUN;
                op_q    <= cmd_op;
                phy_q   <= cmd_phy;
                code_q  <= cmd_code;
                wdata_q <= cmd_wdata;
                step_q  <= '0;
            end else if (advance) begin
                step_q <= nxt_step;
                if ((op_q == TIF_OP_READ) && (nxt_step == CAPTURE_STEP)) begin
                    cap_q <= tdout_sel;
                end
            end else if (finish) begin
                state_q <= SQ_IDLE;
                if (is_xfer_q) begin
                    rsp_valid <= 1'b1;
                    rsp_data  <= (op_q == TIF_OP_READ) ? cap_q : tdout_sel;
                end
            end
        end
    end

    assign cmd_ready = (state_q == SQ_IDLE);
    assign cur_phy   = phy_q;
endmodule

// File: rtl/tif_pin_bank.sv
// Pin bank for one PHY instance: holds its test pins and applies an action
// only when that action is addressed to this instance.
// Assumes at most one action per cycle.
module tif_pin_bank
    import tif_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int SEL_W  = 1,
    parameter int INDEX  = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              act_fire,
    input  tif_act_e          act_kind,
    input  logic [SEL_W-1:0]  act_phy,
    input  logic [DATA_W-1:0] act_byte,
    output logic              tclk,
    output logic              ten,
    output logic [DATA_W-1:0] tdin,
    output logic              tclr
);
    logic hit;

    assign hit = act_fire && (act_phy == SEL_W'(INDEX));

    // Apply the addressed action to this instance's pins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tclk <= 1'b0;
            ten  <= 1'b0;
            tdin <= '0;
            tclr <= 1'b0;
        end else if (hit) begin
            case (act_kind)
                ACT_CLK_HI: tclk <= 1'b1;
                ACT_CLK_LO: tclk <= 1'b0;
                ACT_EN_HI:  ten  <= 1'b1;
                ACT_EN_LO:  ten  <= 1'b0;
                ACT_DIN:    tdin <= act_byte;
                ACT_CLR_HI: tclr <= 1'b1;
                ACT_CLR_LO: tclr <= 1'b0;
                default:    ;
            endcase
        end
    end
endmodule

// File: rtl/phy_test_if_master.sv
// PHY test interface master: runs write, read and test-clear commands on
// the test port of the selected PHY instance, one pin change per hold.
// Assumes cmd_phy < NUM_PHY and HOLD_CYC >= 1.
module phy_test_if_master
    import tif_pkg::*;
#(
    parameter int NUM_PHY  = 2,
    parameter int DATA_W   = 8,
    parameter int HOLD_CYC = 100,
    parameter int SEL_W    = (NUM_PHY > 1) ? $clog2(NUM_PHY) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cmd_valid,
    output logic                      cmd_ready,
    input  logic [1:0]                cmd_op,
    input  logic [SEL_W-1:0]          cmd_phy,
    input  logic [DATA_W-1:0]         cmd_code,
    input  logic [DATA_W-1:0]         cmd_wdata,
    output logic                      rsp_valid,
    output logic [DATA_W-1:0]         rsp_data,
    output logic [NUM_PHY-1:0]        tclk_o,
    output logic [NUM_PHY-1:0]        ten_o,
    output logic [NUM_PHY*DATA_W-1:0] tdin_o,
    output logic [NUM_PHY-1:0]        tclr_o,
    input  logic [NUM_PHY*DATA_W-1:0] tdout_i
);
    logic              hold_done;
    logic              act_fire;
    tif_act_e          act_kind;
    logic [SEL_W-1:0]  act_phy;
    logic [DATA_W-1:0] act_byte;
    logic [SEL_W-1:0]  cur_phy;
    logic [DATA_W-1:0] tdout_sel;
    logic [DATA_W-1:0] dout_arr [NUM_PHY];

    tif_hold_timer #(.HOLD_CYC(HOLD_CYC)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (act_fire),
        .expired (hold_done)
    );

    tif_sequencer #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_ready (cmd_ready),
        .cmd_op    (tif_op_e'(cmd_op)),
        .cmd_phy   (cmd_phy),
        .cmd_code  (cmd_code),
        .cmd_wdata (cmd_wdata),
        .hold_done (hold_done),
        .tdout_sel (tdout_sel),
        .cur_phy   (cur_phy),
        .act_fire  (act_fire),
        .act_kind  (act_kind),
        .act_phy   (act_phy),
        .act_byte  (act_byte),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data)
    );

    for (genvar i = 0; i < NUM_PHY; i++) begin : g_phy
        tif_pin_bank #(.DATA_W(DATA_W), .SEL_W(SEL_W), .INDEX(i)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .act_fire (act_fire),
            .act_kind (act_kind),
            .act_phy  (act_phy),
            .act_byte (act_byte),
            .tclk     (tclk_o[i]),
            .ten      (ten_o[i]),
            .tdin     (tdin_o[i*DATA_W +: DATA_W]),
            .tclr     (tclr_o[i])
        );
        assign dout_arr[i] = tdout_i[i*DATA_W +: DATA_W];
    end

    assign tdout_sel = dout_arr[cur_phy];
endmodule

// File: rtl/tif_checker.sv
// Checker for phy_test_if_master: handshake, response strobe, pin ordering,
// instance isolation and minimum spacing between pin changes.
// Assumes pins are observed at the block's ports only.
module tif_checker #(
    parameter int NUM_PHY  = 2,
    parameter int DATA_W   = 8,
    parameter int HOLD_CYC = 100
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      cmd_valid,
    input logic                      cmd_ready,
    input logic                      rsp_valid,
    input logic [NUM_PHY-1:0]        tclk_o,
    input logic [NUM_PHY-1:0]        ten_o,
    input logic [NUM_PHY*DATA_W-1:0] tdin_o,
    input logic [NUM_PHY-1:0]        tclr_o
);
    localparam int PIN_W = 3 + DATA_W;

    logic [NUM_PHY*PIN_W-1:0] pins_now;
    logic [NUM_PHY*PIN_W-1:0] pins_prev;
    logic [NUM_PHY-1:0]       phy_chg;
    logic [31:0]              gap_q;

    for (genvar i = 0; i < NUM_PHY; i++) begin : g_pins
        assign pins_now[i*PIN_W +: PIN_W] =
            {tclk_o[i], ten_o[i], tclr_o[i], tdin_o[i*DATA_W +: DATA_W]};
        assign phy_chg[i] = (pins_now[i*PIN_W +: PIN_W] != pins_prev[i*PIN_W +: PIN_W]);

        assert_en_rise_clk_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(ten_o[i]) |-> tclk_o[i]);
    end

    // Track previous pins and cycles since the last pin change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pins_prev <= '0;
            gap_q     <= 32'(HOLD_CYC);
        end else begin
            pins_prev <= pins_now;
            if (|phy_chg) begin
                gap_q <= 32'd1;
            end else if (gap_q < 32'(HOLD_CYC)) begin
                gap_q <= gap_q + 32'd1;
            end
        end
    end

    assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> !cmd_ready);

    assert_rsp_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> cmd_ready);

    assert_rsp_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    assert_one_phy_moves_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(phy_chg));

    assert_hold_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|phy_chg) |-> (gap_q >= 32'(HOLD_CYC)));
endmodule

bind phy_test_if_master tif_checker #(
    .NUM_PHY  (NUM_PHY),
    .DATA_W   (DATA_W),
    .HOLD_CYC (HOLD_CYC)
) u_tif_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .rsp_valid (rsp_valid),
    .tclk_o    (tclk_o),
    .ten_o     (ten_o),
    .tdin_o    (tdin_o),
    .tclr_o    (tclr_o)
);

// File: tb/test_phy_test_if_master.sv
// Scoreboard bench: driver tasks queue the expected response and its due
// cycle; a monitor compares them when rsp_valid appears. A small PHY model
// latches the code on a falling test clock with enable high and stores data
// on a rising test clock with enable low.
module test_phy_test_if_master;
    localparam int CLK_PERIOD = 10;
    localparam int H  = 3;
    localparam int NP = 2;
    localparam int DW = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cmd_valid = 1'b0;
    logic            cmd_ready;
    logic [1:0]      cmd_op = 2'd0;
    logic [0:0]      cmd_phy = 1'b0;
    logic [DW-1:0]   cmd_code = '0;
    logic [DW-1:0]   cmd_wdata = '0;
    logic            rsp_valid;
    logic [DW-1:0]   rsp_data;
    logic [NP-1:0]   tclk_o, ten_o, tclr_o;
    logic [NP*DW-1:0] tdin_o, tdout_i;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    bit done     = 1'b0;

    logic [7:0] exp_data_q [$];
    int         exp_cyc_q  [$];
    logic [7:0] shadow [NP][256];
    logic [7:0] last_din [NP];

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    phy_test_if_master #(.NUM_PHY(NP), .DATA_W(DW), .HOLD_CYC(H)) i_phy_test_if_master (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_phy(cmd_phy), .cmd_code(cmd_code), .cmd_wdata(cmd_wdata),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .tclk_o(tclk_o), .ten_o(ten_o),
        .tdin_o(tdin_o), .tclr_o(tclr_o), .tdout_i(tdout_i)
    );

    function automatic logic [7:0] init_val(int p, logic [7:0] a);
        return a ^ {a[6:0], 1'b0} ^ ((p != 0) ? {a[3:0], a[7:4]} : 8'h00);
    endfunction

    for (genvar p = 0; p < NP; p++) begin : g_model
        logic [7:0] mem [256];
        logic [7:0] addr;
        initial begin
            for (int a = 0; a < 256; a++) mem[a] = init_val(p, 8'(a));
            addr = 8'h00;
        end
        always @(negedge tclk_o[p]) if (ten_o[p] === 1'b1) addr = tdin_o[p*DW +: DW];
        always @(posedge tclk_o[p]) if (ten_o[p] === 1'b0) mem[addr] = tdin_o[p*DW +: DW];
        assign tdout_i[p*DW +: DW] = mem[addr];
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [10:0] pins_of(int p);
        return {tclk_o[p], ten_o[p], tclr_o[p], tdin_o[p*DW +: DW]};
    endfunction

    // Monitor: compare each response with the queued expectation and due cycle.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_data_q.size() == 0) begin
                check(1'b0, "R5 unexpected response", 32'(rsp_data), 32'hFFFF_FFFF);
            end else begin
                logic [7:0] ed;
                int ec;
                ed = exp_data_q.pop_front();
                ec = exp_cyc_q.pop_front();
                check(rsp_data == ed, "R5/R6 response data", 32'(rsp_data), 32'(ed));
                check(cyc == ec, "R7 response cycle", 32'(cyc), 32'(ec));
            end
        end
    end

    // Driver for a read or write: check every pin step and its hold, queue the response.
    task automatic do_xfer(input bit is_read, input int phy, input logic [7:0] code, input logic [7:0] data);
        logic [7:0]  exp_rsp;
        logic [7:0]  d;
        logic [10:0] step_pins [8];
        logic [10:0] other;
        logic        clr;
        int          op_phy;
        op_phy  = 1 - phy;
        exp_rsp = is_read ? shadow[phy][code] : data;
        if (!is_read) shadow[phy][code] = data;
        d   = exp_rsp;
        clr = tclr_o[phy];
        step_pins[0] = {1'b1, 1'b0, clr, last_din[phy]};
        step_pins[1] = {1'b1, 1'b0, clr, code};
        step_pins[2] = {1'b1, 1'b1, clr, code};
        step_pins[3] = {1'b0, 1'b1, clr, code};
        step_pins[4] = {1'b0, 1'b0, clr, code};
        step_pins[5] = {1'b0, 1'b0, clr, code};
        step_pins[6] = {1'b0, 1'b0, clr, d};
        step_pins[7] = {1'b1, 1'b0, clr, d};
        other = pins_of(op_phy);
        check(cmd_ready == 1'b1, "R2 ready before command", 32'(cmd_ready), 32'd1);
        cmd_valid = 1'b1;
        cmd_op    = is_read ? 2'd1 : 2'd0;
        cmd_phy   = 1'(phy);
        cmd_code  = code;
        cmd_wdata = data;
        exp_data_q.push_back(exp_rsp);
        exp_cyc_q.push_back(cyc + 1 + 8*H);
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        check(pins_of(phy) == step_pins[0], "R3 step 0 test clock high", 32'(pins_of(phy)), 32'(step_pins[0]));
        check(cmd_ready == 1'b0, "R2 busy after accept", 32'(cmd_ready), 32'd0);
        for (int k = 1; k < 8; k++) begin
            repeat (H-1) @(posedge clk);
            @(negedge clk);
            check(pins_of(phy) == step_pins[k-1], "R7 pins held through hold", 32'(pins_of(phy)), 32'(step_pins[k-1]));
            @(posedge clk);
            @(negedge clk);
            check(pins_of(phy) == step_pins[k], (k < 5) ? "R3 code phase step" : "R4/R6 data phase step",
                  32'(pins_of(phy)), 32'(step_pins[k]));
            check(pins_of(op_phy) == other, "R8 other instance untouched", 32'(pins_of(op_phy)), 32'(other));
            check(rsp_valid == 1'b0, "R7 no early response", 32'(rsp_valid), 32'd0);
        end
        repeat (H) @(posedge clk);
        @(negedge clk);
        check(cmd_ready == 1'b1, "R2 ready after completion", 32'(cmd_ready), 32'd1);
        last_din[phy] = d;
    endtask

    // Driver for test-clear set or release.
    task automatic do_clr(input int phy, input bit level);
        logic [10:0] own_exp;
        logic [10:0] other;
        own_exp = pins_of(phy);
        own_exp[8] = level;
        other = pins_of(1 - phy);
        cmd_valid = 1'b1;
        cmd_op    = level ? 2'd2 : 2'd3;
        cmd_phy   = 1'(phy);
        cmd_code  = 8'hEE;
        cmd_wdata = 8'h77;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        check(pins_of(phy) == own_exp, "R9 test-clear level, other pins held", 32'(pins_of(phy)), 32'(own_exp));
        check(pins_of(1 - phy) == other, "R8 other instance untouched by clear", 32'(pins_of(1 - phy)), 32'(other));
        check(cmd_ready == 1'b0, "R9 busy during clear hold", 32'(cmd_ready), 32'd0);
        repeat (H) @(posedge clk);
        @(negedge clk);
        check(cmd_ready == 1'b1, "R9 ready one hold after clear", 32'(cmd_ready), 32'd1);
    endtask

    task automatic finish_sim();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        check(1'b0, "watchdog expired", 32'd0, 32'd1);
        finish_sim();
    end

    initial begin
        for (int p = 0; p < NP; p++) begin
            last_din[p] = 8'h00;
            for (int a = 0; a < 256; a++) shadow[p][a] = init_val(p, 8'(a));
        end
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(tclk_o == '0 && ten_o == '0 && tdin_o == '0 && tclr_o == '0, "R1 pins low in reset",
              32'({tclk_o, ten_o, tclr_o}), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check({tclk_o, ten_o, tclr_o, tdin_o} == '0, "R1 pins low after reset", 32'(tdin_o), 32'd0);
        check(cmd_ready == 1'b1 && rsp_valid == 1'b0, "R1 ready high, no response", 32'({cmd_ready, rsp_valid}), 32'h2);

        do_xfer(1'b0, 0, 8'h44, 8'h2B);
        do_xfer(1'b1, 0, 8'h44, 8'h00);
        do_xfer(1'b1, 0, 8'h71, 8'h00);
        do_xfer(1'b1, 1, 8'h44, 8'h00);
        do_clr(1, 1'b1);
        do_xfer(1'b0, 0, 8'h62, 8'hC5);
        check(tclr_o[1] == 1'b1, "R8 clear of instance 1 held during instance 0 write", 32'(tclr_o[1]), 32'd1);
        do_clr(1, 1'b0);
        do_clr(0, 1'b1);
        do_xfer(1'b1, 0, 8'h62, 8'h00);
        do_clr(0, 1'b0);
        do_xfer(1'b0, 1, 8'h00, 8'hFF);
        do_xfer(1'b1, 1, 8'h00, 8'h00);
        do_xfer(1'b0, 1, 8'hFF, 8'h5A);
        do_xfer(1'b1, 1, 8'hFF, 8'h00);

        repeat (3) @(negedge clk);
        check(exp_data_q.size() == 0, "R5 all responses seen", 32'(exp_data_q.size()), 32'd0);
        finish_sim();
    end
endmodule